// File: doc/BRIEF.md
# Transmit Gather and Enqueue Sequencer

This block takes transmit descriptors from a set of virtual contexts and turns them into packets in a transmit FIFO. Each descriptor names a source address, a byte count, a flag saying whether more chunks of the same packet follow, and a flag asking for checksum insertion. Contexts are served strictly in the order their descriptors arrived. For each descriptor the sequencer waits until the FIFO has room for the bytes already gathered plus the new chunk. It then issues one DMA read and waits for its acknowledge, and it records a per-context completion word.

Chained descriptors whose more flag is set are gathered into one open packet. Each chunk lands at the running buffer offset, and a DMA interrupt is raised after each chunk. The chunk without the more flag closes the packet. If that chunk asks for it, a checksum request pulse comes first. The packet is then pushed into the FIFO with its total length, and a FIFO-full interrupt is raised when the space left falls below a programmable copy limit. A separate path raises packet-sent and FIFO-low interrupts whenever the downstream transmitter reports a send.

Top module: `tx_gather_seq`

## Requirements
- R1: After reset, `dma_req`, `fifo_push`, `csum_req`, `done_valid` and all four interrupt outputs are low, and every context's completion word reads zero.
- R2: While `tx_en` is low no descriptor is served. Once `tx_en` is high and the sequencer is idle, the queued work starts.
- R3: Descriptors from different contexts are served in the order they were written.
- R4: A descriptor written for a context that already sits at the head of the queue replaces that context's descriptor and does not add a second queue entry, so only one DMA read results.
- R5: No DMA read is issued while `fifo_free` is less than the bytes already gathered for the open packet plus the head descriptor's length. The read starts once space allows.
- R6: `dma_req` stays high, carrying the head descriptor's address on `dma_addr` and its length on `dma_len`, until the cycle `dma_ack` is seen.
- R7: When a chunk's DMA completes, `done_valid` pulses with the context and length. That context's completion word becomes its length with bit LEN_W (the completion bit) set.
- R8: A chunk with the more flag raises `irq_txdma` and does not push. The next chunk is read at `dma_buf_off` equal to the sum of the earlier chunk lengths.
- R9: The final chunk of a packet causes one `fifo_push` whose `push_len` is the total gathered length, with `irq_txdma` high in the same cycle.
- R10: When the final chunk carries the checksum flag, `csum_req` pulses exactly one cycle before the push. Without the flag it stays low.
- R11: `irq_txfull` is raised together with the push when `fifo_free` minus the pushed length is below `max_copy`, and not otherwise.
- R12: One cycle after a `tx_sent` pulse, `irq_txpkt` pulses. `irq_txlow` pulses with it when FIFO_BYTES minus `fifo_free` is below `low_mark`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit sequencing enable |
| desc_wr | input | 1 | Descriptor write strobe |
| desc_ctx | input | ID_W | Context the descriptor belongs to |
| desc_addr | input | ADDR_W | Source address of the chunk |
| desc_len | input | LEN_W | Chunk length in bytes |
| desc_more | input | 1 | More chunks of this packet follow |
| desc_csum | input | 1 | Request checksum insertion on the final chunk |
| dma_req | output | 1 | DMA read request, held until acknowledged |
| dma_addr | output | ADDR_W | DMA source address |
| dma_len | output | LEN_W | DMA byte count |
| dma_buf_off | output | LEN_W | Destination offset inside the packet buffer |
| dma_ack | input | 1 | DMA read completed |
| fifo_free | input | FREE_W | Free bytes in the transmit FIFO |
| max_copy | input | FREE_W | Free-space level below which the full interrupt is raised |
| low_mark | input | FREE_W | Fill level below which the low interrupt is raised |
| fifo_push | output | 1 | Push the assembled packet into the FIFO |
| push_len | output | LEN_W | Length of the pushed packet |
| csum_req | output | 1 | Checksum insertion request pulse |
| done_valid | output | 1 | Chunk completion pulse |
| done_ctx | output | ID_W | Context of the completed chunk |
| done_len | output | LEN_W | Length of the completed chunk |
| done_words | output | N_CTX*(LEN_W+1) | Per-context completion words, context c at bits c*(LEN_W+1) and up |
| tx_sent | input | 1 | Downstream transmitter sent one packet |
| irq_txdma | output | 1 | Transmit DMA interrupt pulse |
| irq_txfull | output | 1 | FIFO nearly full interrupt pulse |
| irq_txpkt | output | 1 | Packet sent interrupt pulse |
| irq_txlow | output | 1 | FIFO low interrupt pulse |

## Verification
The bench builds the block with four contexts, 16-bit addresses and a 4096-byte FIFO and maximum packet. This makes LEN_W and FREE_W both 13 bits. With a FIFO this small, the bench can drive `fifo_free` below the gathered-plus-next-chunk sum and hold off a DMA read, and it can place the full and low thresholds on either side of a push or a send. Four contexts are enough to queue three distinct contexts behind a disabled enable and to repeat a write to the head context.

// File: rtl/txg_pkg.sv
package txg_pkg;

    typedef enum logic [2:0] {
        TXG_IDLE     = 3'd0,
        TXG_FBLOCK   = 3'd1,
        TXG_BEGIN    = 3'd2,
        TXG_COPY     = 3'd3,
        TXG_CDONE    = 3'd4,
        TXG_COMPLETE = 3'd5
    } txg_state_e;

endpackage

// File: rtl/txg_ctx_queue.sv
// Arrival-order ring of context ids; a push is dropped when the id already heads the ring.
module txg_ctx_queue #(
    parameter int N_CTX = 4,
    parameter int ID_W  = 2,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic [ID_W-1:0]  push_id,
    input  logic             pop,
    output logic [ID_W-1:0]  head_id,
    output logic [CNT_W-1:0] count
);
    localparam int PTR_W = (N_CTX > 1) ? $clog2(N_CTX) : 1;

    typedef struct packed {
        logic [N_CTX-1:0][ID_W-1:0] slot;
        logic [PTR_W-1:0]           rd;
        logic [PTR_W-1:0]           wr;
        logic [CNT_W-1:0]           cnt;
    } q_regs_t;

    q_regs_t q_d, q_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(N_CTX - 1)) bump = '0;
        else                        bump = p + 1'b1;
    endfunction

    logic at_head;
    logic do_push;
    logic do_pop;

    always_comb begin
        at_head = (q_q.cnt != '0) && (q_q.slot[q_q.rd] == push_id);
        do_pop  = pop && (q_q.cnt != '0);
        do_push = push_req && !at_head && ((q_q.cnt != CNT_W'(N_CTX)) || do_pop);

        q_d = q_q;
        if (do_push) begin
            q_d.slot[q_q.wr] = push_id;
            q_d.wr           = bump(q_q.wr);
        end
        if (do_pop) begin
            q_d.rd = bump(q_q.rd);
        end
        case ({do_push, do_pop})
            2'b10:   q_d.cnt = q_q.cnt + 1'b1;
            2'b01:   q_d.cnt = q_q.cnt - 1'b1;
            default: q_d.cnt = q_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign head_id = q_q.slot[q_q.rd];
    assign count   = q_q.cnt;

endmodule

// File: rtl/txg_desc_bank.sv
// Per-context descriptor registers and completion words.
module txg_desc_bank #(
    parameter int N_CTX  = 4,
    parameter int ID_W   = 2,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 15
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ID_W-1:0]            wr_id,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [LEN_W-1:0]           wr_len,
    input  logic                       wr_more,
    input  logic                       wr_csum,
    input  logic [ID_W-1:0]            rd_id,
    output logic [ADDR_W-1:0]          rd_addr,
    output logic [LEN_W-1:0]           rd_len,
    output logic                       rd_more,
    output logic                       rd_csum,
    input  logic                       done_en,
    input  logic [ID_W-1:0]            done_id,
    input  logic [LEN_W-1:0]           done_len,
    output logic [N_CTX*(LEN_W+1)-1:0] done_words
);
    localparam int WORD_W = LEN_W + 1;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic              more;
        logic              csum;
        logic [WORD_W-1:0] done;
    } entry_t;

    entry_t ent_q [N_CTX];

    for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
        entry_t ent_d;

        always_comb begin
            ent_d = ent_q[c];
            if (wr_en && (wr_id == ID_W'(c))) begin
                ent_d.addr = wr_addr;
                ent_d.len  = wr_len;
                ent_d.more = wr_more;
                ent_d.csum = wr_csum;
                ent_d.done = '0;
            end
            if (done_en && (done_id == ID_W'(c))) begin
                ent_d.done = {1'b1, done_len};
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) ent_q[c] <= '0;
            else        ent_q[c] <= ent_d;
        end

        assign done_words[c*WORD_W +: WORD_W] = ent_q[c].done;
    end

    assign rd_addr = ent_q[rd_id].addr;
    assign rd_len  = ent_q[rd_id].len;
    assign rd_more = ent_q[rd_id].more;
    assign rd_csum = ent_q[rd_id].csum;

endmodule

// File: rtl/txg_send_irq.sv
// Interrupts raised when the downstream transmitter reports a send.
module txg_send_irq #(
    parameter int FIFO_BYTES = 32768,
    parameter int FREE_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_sent,
    input  logic [FREE_W-1:0] fifo_free,
    input  logic [FREE_W-1:0] low_mark,
    output logic              irq_pkt,
    output logic              irq_low
);
    typedef struct packed {
        logic pkt;
        logic low;
    } s_regs_t;

    s_regs_t s_d, s_q;
    logic [FREE_W-1:0] level;

    always_comb begin
        level   = FREE_W'(FIFO_BYTES) - fifo_free;
        s_d.pkt = tx_sent;
        s_d.low = tx_sent && (level < low_mark);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq_pkt = s_q.pkt;
    assign irq_low = s_q.low;

endmodule

// File: rtl/tx_gather_seq.sv
module tx_gather_seq #(
    parameter int N_CTX      = 4,
    parameter int ADDR_W     = 32,
    parameter int MAX_PKT    = 16384,
    parameter int FIFO_BYTES = 32768,
    localparam int ID_W      = (N_CTX > 1) ? $clog2(N_CTX) : 1,
    localparam int LEN_W     = $clog2(MAX_PKT + 1),
    localparam int FREE_W    = $clog2(FIFO_BYTES + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tx_en,
    input  logic                       desc_wr,
    input  logic [ID_W-1:0]            desc_ctx,
    input  logic [ADDR_W-1:0]          desc_addr,
    input  logic [LEN_W-1:0]           desc_len,
    input  logic                       desc_more,
    input  logic                       desc_csum,
    output logic                       dma_req,
    output logic [ADDR_W-1:0]          dma_addr,
    output logic [LEN_W-1:0]           dma_len,
    output logic [LEN_W-1:0]           dma_buf_off,
    input  logic                       dma_ack,
    input  logic [FREE_W-1:0]          fifo_free,
    input  logic [FREE_W-1:0]          max_copy,
    input  logic [FREE_W-1:0]          low_mark,
    output logic                       fifo_push,
    output logic [LEN_W-1:0]           push_len,
    output logic                       csum_req,
    output logic                       done_valid,
    output logic [ID_W-1:0]            done_ctx,
    output logic [LEN_W-1:0]           done_len,
    output logic [N_CTX*(LEN_W+1)-1:0] done_words,
    input  logic                       tx_sent,
    output logic                       irq_txdma,
    output logic                       irq_txfull,
    output logic                       irq_txpkt,
    output logic                       irq_txlow
);
    import txg_pkg::*;

    localparam int CNT_W = $clog2(N_CTX + 1);
    localparam int SUM_W = ((LEN_W > FREE_W) ? LEN_W : FREE_W) + 1;

    typedef struct packed {
        txg_state_e       state;
        logic [LEN_W-1:0] gathered;
        logic [LEN_W-1:0] offset;
        logic             done_v;
        logic [ID_W-1:0]  done_ctx;
        logic [LEN_W-1:0] done_len;
        logic             csum;
        logic             push;
        logic [LEN_W-1:0] push_len;
        logic             irq_dma;
        logic             irq_full;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [ID_W-1:0]   head_ctx;
    logic [CNT_W-1:0]  q_count;
    logic              q_pop;
    logic [ADDR_W-1:0] hd_addr;
    logic [LEN_W-1:0]  hd_len;
    logic              hd_more;
    logic              hd_csum;
    logic [SUM_W-1:0]  free_x;
    logic [SUM_W-1:0]  need_x;
    logic [SUM_W-1:0]  full_x;
    txg_state_e        after_pop;

    txg_ctx_queue #(
        .N_CTX (N_CTX),
        .ID_W  (ID_W),
        .CNT_W (CNT_W)
    ) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (desc_wr),
        .push_id  (desc_ctx),
        .pop      (q_pop),
        .head_id  (head_ctx),
        .count    (q_count)
    );

    txg_desc_bank #(
        .N_CTX  (N_CTX),
        .ID_W   (ID_W),
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (desc_wr),
        .wr_id      (desc_ctx),
        .wr_addr    (desc_addr),
        .wr_len     (desc_len),
        .wr_more    (desc_more),
        .wr_csum    (desc_csum),
        .rd_id      (head_ctx),
        .rd_addr    (hd_addr),
        .rd_len     (hd_len),
        .rd_more    (hd_more),
        .rd_csum    (hd_csum),
        .done_en    (r_q.state == TXG_CDONE),
        .done_id    (head_ctx),
        .done_len   (hd_len),
        .done_words (done_words)
    );

    txg_send_irq #(
        .FIFO_BYTES (FIFO_BYTES),
        .FREE_W     (FREE_W)
    ) u_send_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_sent   (tx_sent),
        .fifo_free (fifo_free),
        .low_mark  (low_mark),
        .irq_pkt   (irq_txpkt),
        .irq_low   (irq_txlow)
    );

    // Space comparisons are done as sums so nothing underflows.
    always_comb begin
        free_x = {{(SUM_W-FREE_W){1'b0}}, fifo_free};
        need_x = {{(SUM_W-LEN_W){1'b0}}, r_q.gathered}
               + {{(SUM_W-LEN_W){1'b0}}, hd_len};
        full_x = {{(SUM_W-LEN_W){1'b0}}, r_q.gathered}
               + {{(SUM_W-FREE_W){1'b0}}, max_copy};
        after_pop = (q_count > CNT_W'(1)) ? TXG_FBLOCK : TXG_IDLE;
        q_pop = ((r_q.state == TXG_CDONE) && hd_more) || (r_q.state == TXG_COMPLETE);
    end

    always_comb begin
        r_d          = r_q;
        r_d.done_v   = 1'b0;
        r_d.csum     = 1'b0;
        r_d.push     = 1'b0;
        r_d.irq_dma  = 1'b0;
        r_d.irq_full = 1'b0;

        case (r_q.state)
            TXG_IDLE: begin
                if (tx_en && ((q_count != '0) || desc_wr)) begin
                    r_d.state = TXG_FBLOCK;
                end
            end
            TXG_FBLOCK: begin
                if (free_x >= need_x) begin
                    r_d.state = TXG_BEGIN;
                end
            end
            TXG_BEGIN: begin
                r_d.state = TXG_COPY;
            end
            TXG_COPY: begin
                if (dma_ack) begin
                    r_d.state = TXG_CDONE;
                end
            end
            TXG_CDONE: begin
                r_d.done_v   = 1'b1;
                r_d.done_ctx = head_ctx;
                r_d.done_len = hd_len;
                r_d.gathered = r_q.gathered + hd_len;
                if (hd_more) begin
                    r_d.offset  = r_q.offset + hd_len;
                    r_d.irq_dma = 1'b1;
                    r_d.state   = after_pop;
                end else begin
                    r_d.csum  = hd_csum;
                    r_d.state = TXG_COMPLETE;
                end
            end
            TXG_COMPLETE: begin
                r_d.push     = 1'b1;
                r_d.push_len = r_q.gathered;
                r_d.irq_full = free_x < full_x;
                r_d.irq_dma  = 1'b1;
                r_d.gathered = '0;
                r_d.offset   = '0;
                r_d.state    = after_pop;
            end
            default: begin
                r_d.state = TXG_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign dma_req     = (r_q.state == TXG_COPY);
    assign dma_addr    = hd_addr;
    assign dma_len     = hd_len;
    assign dma_buf_off = r_q.offset;
    assign fifo_push   = r_q.push;
    assign push_len    = r_q.push_len;
    assign csum_req    = r_q.csum;
    assign done_valid  = r_q.done_v;
    assign done_ctx    = r_q.done_ctx;
    assign done_len    = r_q.done_len;
    assign irq_txdma   = r_q.irq_dma;
    assign irq_txfull  = r_q.irq_full;

endmodule

// File: rtl/txg_seq_chk.sv
module txg_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic dma_req,
    input logic dma_ack,
    input logic csum_req,
    input logic fifo_push,
    input logic irq_txdma,
    input logic irq_txfull,
    input logic irq_txpkt,
    input logic irq_txlow,
    input logic tx_sent
);
    // R6
    dma_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_ack) |=> dma_req);

    // R10
    csum_then_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csum_req |=> fifo_push);

    // R11
    full_with_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_txfull |-> fifo_push);

    // R9
    push_dma_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> irq_txdma);

    // R12
    sent_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sent |=> irq_txpkt);

    // R12
    low_with_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_txlow |-> irq_txpkt);

    // R8
    no_req_on_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> !dma_req);
endmodule

bind tx_gather_seq txg_seq_chk u_chk (.*);

// File: tb/tx_gather_seq_tb.sv
`timescale 1ns/1ps
module tx_gather_seq_tb;
    localparam int N_CTX  = 4;
    localparam int ADDR_W = 16;
    localparam int MAXP   = 4096;
    localparam int FBYTES = 4096;
    localparam int ID_W   = 2;
    localparam int LEN_W  = 13;
    localparam int FREE_W = 13;
    localparam int WORD_W = LEN_W + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 1'b0;
    logic desc_wr = 1'b0;
    logic [ID_W-1:0] desc_ctx = '0;
    logic [ADDR_W-1:0] desc_addr = '0;
    logic [LEN_W-1:0] desc_len = '0;
    logic desc_more = 1'b0;
    logic desc_csum = 1'b0;
    logic dma_req;
    logic [ADDR_W-1:0] dma_addr;
    logic [LEN_W-1:0] dma_len;
    logic [LEN_W-1:0] dma_buf_off;
    logic dma_ack = 1'b0;
    logic [FREE_W-1:0] fifo_free = FREE_W'(4000);
    logic [FREE_W-1:0] max_copy = '0;
    logic [FREE_W-1:0] low_mark = '0;
    logic fifo_push;
    logic [LEN_W-1:0] push_len;
    logic csum_req;
    logic done_valid;
    logic [ID_W-1:0] done_ctx;
    logic [LEN_W-1:0] done_len;
    logic [N_CTX*WORD_W-1:0] done_words;
    logic tx_sent = 1'b0;
    logic irq_txdma, irq_txfull, irq_txpkt, irq_txlow;

    tx_gather_seq #(
        .N_CTX(N_CTX), .ADDR_W(ADDR_W), .MAX_PKT(MAXP), .FIFO_BYTES(FBYTES)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en),
        .desc_wr(desc_wr), .desc_ctx(desc_ctx), .desc_addr(desc_addr),
        .desc_len(desc_len), .desc_more(desc_more), .desc_csum(desc_csum),
        .dma_req(dma_req), .dma_addr(dma_addr), .dma_len(dma_len),
        .dma_buf_off(dma_buf_off), .dma_ack(dma_ack),
        .fifo_free(fifo_free), .max_copy(max_copy), .low_mark(low_mark),
        .fifo_push(fifo_push), .push_len(push_len), .csum_req(csum_req),
        .done_valid(done_valid), .done_ctx(done_ctx), .done_len(done_len),
        .done_words(done_words), .tx_sent(tx_sent),
        .irq_txdma(irq_txdma), .irq_txfull(irq_txfull),
        .irq_txpkt(irq_txpkt), .irq_txlow(irq_txlow)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    int dma_cnt = 0;
    int log_addr [64];
    int log_len  [64];
    int log_off  [64];
    int push_cnt = 0, last_push = 0, csum_cnt = 0, csum_push_cnt = 0;
    int dirq_cnt = 0, full_cnt = 0, pkt_cnt = 0, low_cnt = 0;
    int done_cnt = 0, last_dctx = 0, last_dlen = 0;
    bit prev_csum = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            finish_run();
        end
    end

    // DMA responder: acknowledges one cycle after a request is seen, logging it.
    initial begin
        forever begin
            @(negedge clk);
            if (dma_ack) begin
                dma_ack = 1'b0;
            end else if (rst_n && dma_req) begin
                log_addr[dma_cnt % 64] = int'(dma_addr);
                log_len[dma_cnt % 64]  = int'(dma_len);
                log_off[dma_cnt % 64]  = int'(dma_buf_off);
                dma_cnt++;
                dma_ack = 1'b1;
            end
        end
    end

    // Output event monitor.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (fifo_push) begin
                    push_cnt++;
                    last_push = int'(push_len);
                    if (prev_csum) csum_push_cnt++;
                end
                prev_csum = csum_req;
                if (csum_req)   csum_cnt++;
                if (irq_txdma)  dirq_cnt++;
                if (irq_txfull) full_cnt++;
                if (irq_txpkt)  pkt_cnt++;
                if (irq_txlow)  low_cnt++;
                if (done_valid) begin
                    done_cnt++;
                    last_dctx = int'(done_ctx);
                    last_dlen = int'(done_len);
                end
            end
        end
    end

    task automatic write_desc(input int ctx, input int addr, input int len,
                              input bit more, input bit csum);
        @(negedge clk);
        desc_wr   = 1'b1;
        desc_ctx  = ID_W'(ctx);
        desc_addr = ADDR_W'(addr);
        desc_len  = LEN_W'(len);
        desc_more = more;
        desc_csum = csum;
        @(negedge clk);
        desc_wr = 1'b0;
    endtask

    task automatic wait_push(input int n);
        int t = 0;
        while (push_cnt < n && t < 2000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic wait_done(input int n);
        int t = 0;
        while (done_cnt < n && t < 2000) begin
            @(negedge clk);
            t++;
        end
    endtask

    function automatic int word_of(input int c);
        return int'(done_words[c*WORD_W +: WORD_W]);
    endfunction

    task automatic t_reset();
        @(negedge clk);
        chk("R1 dma_req", int'(dma_req), 0);
        chk("R1 push", int'(fifo_push), 0);
        chk("R1 irqs", int'({irq_txdma, irq_txfull, irq_txpkt, irq_txlow, csum_req, done_valid}), 0);
        chk("R1 done_words", int'(done_words == '0), 1);
    endtask

    task automatic t_enable_gate();
        int d0 = dma_cnt, p0 = push_cnt, c0 = csum_cnt;
        tx_en = 1'b0;
        write_desc(1, 'h0A00, 64, 1'b0, 1'b0);
        repeat (20) @(negedge clk);
        chk("R2 no dma while disabled", dma_cnt - d0, 0);
        tx_en = 1'b1;
        wait_push(p0 + 1);
        chk("R2 served after enable", dma_cnt - d0, 1);
        chk("R6 dma addr", log_addr[d0 % 64], 'h0A00);
        chk("R6 dma len", log_len[d0 % 64], 64);
        chk("R9 push len", last_push, 64);
        chk("R7 done ctx", last_dctx, 1);
        chk("R7 done len", last_dlen, 64);
        chk("R7 done word", word_of(1), (1 << LEN_W) | 64);
        chk("R10 no csum without flag", csum_cnt - c0, 0);
    endtask

    task automatic t_order();
        int d0 = dma_cnt, p0 = push_cnt;
        tx_en = 1'b0;
        write_desc(2, 'h1000, 16, 1'b0, 1'b0);
        write_desc(0, 'h2000, 24, 1'b0, 1'b0);
        write_desc(3, 'h3000, 32, 1'b0, 1'b0);
        tx_en = 1'b1;
        wait_push(p0 + 3);
        chk("R3 first", log_addr[d0 % 64], 'h1000);
        chk("R3 second", log_addr[(d0 + 1) % 64], 'h2000);
        chk("R3 third", log_addr[(d0 + 2) % 64], 'h3000);
        chk("R7 ctx0 word", word_of(0), (1 << LEN_W) | 24);
    endtask

    task automatic t_dup_head();
        int d0 = dma_cnt, p0 = push_cnt;
        tx_en = 1'b0;
        write_desc(3, 'h0300, 32, 1'b0, 1'b0);
        write_desc(3, 'h0340, 48, 1'b0, 1'b0);
        tx_en = 1'b1;
        wait_push(p0 + 1);
        repeat (30) @(negedge clk);
        chk("R4 single dma", dma_cnt - d0, 1);
        chk("R4 single push", push_cnt - p0, 1);
        chk("R4 latest addr", log_addr[d0 % 64], 'h0340);
        chk("R4 latest len", log_len[d0 % 64], 48);
    endtask

    task automatic t_more_csum();
        int d0 = dma_cnt, p0 = push_cnt, q0 = dirq_cnt, n0 = done_cnt;
        int c0 = csum_cnt, cp0 = csum_push_cnt;
        write_desc(0, 'h5000, 100, 1'b1, 1'b0);
        wait_done(n0 + 1);
        repeat (3) @(negedge clk);
        chk("R8 dma irq on more", dirq_cnt - q0, 1);
        chk("R8 no push on more", push_cnt - p0, 0);
        write_desc(0, 'h5100, 50, 1'b0, 1'b1);
        wait_push(p0 + 1);
        chk("R8 second offset", log_off[(d0 + 1) % 64], 100);
        chk("R8 first offset", log_off[d0 % 64], 0);
        chk("R9 gathered push", last_push, 150);
        chk("R9 dma irq count", dirq_cnt - q0, 2);
        chk("R10 csum pulses", csum_cnt - c0, 1);
        chk("R10 csum before push", csum_push_cnt - cp0, 1);
    endtask

    task automatic t_stall();
        int d0 = dma_cnt, p0 = push_cnt, n0 = done_cnt;
        fifo_free = FREE_W'(40);
        write_desc(2, 'h6000, 64, 1'b0, 1'b0);
        repeat (20) @(negedge clk);
        chk("R5 stall on chunk", dma_cnt - d0, 0);
        fifo_free = FREE_W'(4000);
        wait_push(p0 + 1);
        chk("R5 resume", last_push, 64);
        fifo_free = FREE_W'(120);
        write_desc(1, 'h7000, 100, 1'b1, 1'b0);
        wait_done(n0 + 2);
        write_desc(1, 'h7100, 30, 1'b0, 1'b0);
        repeat (20) @(negedge clk);
        chk("R5 stall with gathered bytes", dma_cnt - d0, 2);
        fifo_free = FREE_W'(4000);
        wait_push(p0 + 2);
        chk("R5 gathered push", last_push, 130);
        chk("R8 offset after stall", log_off[(d0 + 2) % 64], 100);
    endtask

    task automatic t_full();
        int p0 = push_cnt, f0 = full_cnt;
        max_copy  = FREE_W'(1000);
        fifo_free = FREE_W'(1100);
        write_desc(0, 'h8000, 200, 1'b0, 1'b0);
        wait_push(p0 + 1);
        repeat (2) @(negedge clk);
        chk("R11 full raised", full_cnt - f0, 1);
        write_desc(0, 'h8100, 50, 1'b0, 1'b0);
        wait_push(p0 + 2);
        repeat (2) @(negedge clk);
        chk("R11 full not raised", full_cnt - f0, 1);
        max_copy  = '0;
        fifo_free = FREE_W'(4000);
    endtask

    task automatic t_sent();
        int k0 = pkt_cnt, l0 = low_cnt;
        low_mark  = FREE_W'(100);
        fifo_free = FREE_W'(4000);
        @(negedge clk); tx_sent = 1'b1;
        @(negedge clk); tx_sent = 1'b0;
        @(negedge clk);
        chk("R12 pkt irq", pkt_cnt - k0, 1);
        chk("R12 low irq below mark", low_cnt - l0, 1);
        fifo_free = FREE_W'(3000);
        @(negedge clk); tx_sent = 1'b1;
        @(negedge clk); tx_sent = 1'b0;
        @(negedge clk);
        chk("R12 pkt irq again", pkt_cnt - k0, 2);
        chk("R12 no low irq above mark", low_cnt - l0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enable_gate();
        t_order();
        t_dup_head();
        t_more_csum();
        t_stall();
        t_full();
        t_sent();
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule